// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of a PCI target-only function's configuration space. Three sticky error flags (detected parity error, signaled system error, signaled target abort) are raised by single-cycle event strobes from the rest of the device. They stay set until the host writes a 1 to their bit position. The remaining bits are either fixed capability and timing codes or a live interrupt-status bit.

The interrupt-status bit follows the OR of the device's interrupt sources, counting only those whose signaling is enabled. A registered, active-low INTx pin is driven from the same condition. The pin is masked by an interrupt-disable input from the command register, and that mask never changes the status bit.

The host port is a plain register port with no valid/ready handshake. The read word is always present on `rd_data`. A write is a single-cycle `wr_en` pulse with two byte enables, and an address decode outside the block selects this register. All event, enable and source inputs are plain level or strobe pins with no back-pressure, because each one is sampled every clock.

Top module: `cfg_status_reg`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `rd_data` reads 16'h0210 and `intx_n` reads 1.
- R2: Bit 15 becomes 1 on the clock edge after a cycle in which `evt_addr_par` or `evt_data_par` is 1.
- R3: Bit 14 becomes 1 on the edge after a cycle in which `evt_sys_err` and `serr_en` are both 1. A system-error strobe with `serr_en` at 0 leaves bit 14 unchanged.
- R4: Bit 11 becomes 1 on the edge after a cycle in which `evt_tgt_abort` is 1.
- R5: A write with `wr_en` at 1 clears each of bits 15, 14 and 11 whose `wr_data` bit is 1 and whose lane enable is 1. Lane enable `wr_be[1]` covers bits 15..8 and `wr_be[0]` covers bits 7..0. A written 0 or a disabled lane leaves the flag unchanged. Without a set or a clear, a flag holds its value.
- R6: When a set event and a write-1 clear hit the same flag in the same cycle, the flag reads 1 afterwards.
- R7: Bits 10..9 always read 01 and bit 4 always reads 1. Bits 13, 12, 8, 7, 6, 5, 2, 1 and 0 always read 0. Writes to these bits have no effect.
- R8: Bit 3 reads the OR over i of `irq_src[i] & irq_src_en[i]` sampled at the previous clock edge. Writes and `int_dis` do not affect it.
- R9: `intx_n` is registered. After each edge it is 0 exactly when the OR of enabled sources was 1 and `int_dis` was 0 in the cycle before that edge, and it is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for this register |
| wr_be | input | 2 | Byte-lane enables (bit 1: bits 15..8, bit 0: bits 7..0) |
| wr_data | input | 16 | Write data; a 1 clears the matching sticky flag |
| rd_data | output | 16 | Current register contents |
| evt_addr_par | input | 1 | Address parity error strobe |
| evt_data_par | input | 1 | Data parity error strobe |
| evt_sys_err | input | 1 | System error strobe |
| serr_en | input | 1 | System-error reporting enable from the command register |
| evt_tgt_abort | input | 1 | Strobe: transaction ended with a target abort |
| irq_src | input | IRQ_SRCS | Interrupt conditions |
| irq_src_en | input | IRQ_SRCS | Per-source signaling enables |
| int_dis | input | 1 | Interrupt-disable bit from the command register |
| intx_n | output | 1 | Registered active-low interrupt pin |

## Verification
The flag logic is swept over every combination of the five event and enable inputs, crossed with every pattern of clear bits and every pair of lane enables. The sweep starts from whatever flag state the preceding step left, so set-only, clear-only, set-versus-clear and held cases all occur. This separates the OR of the two parity strobes from the gated system-error path. It also exposes a clear that ignores its lane enable and any write that reaches a constant bit. A second sweep covers every source and enable pattern under both values of `int_dis`. It shows whether bit 3 honours the per-source enables and whether the INTx mask leaks into the status bit. Directed steps then isolate the written-zero, wrong-lane and same-cycle set-and-clear cases.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;
  localparam int REG_W  = 16;
  localparam int LANE_W = 8;
  localparam int NFLAG  = 3;
  localparam int BIT_IRQ = 3;
  localparam logic [REG_W-1:0] CONST_WORD = 16'h0210;

  // flag index -> bit position: 0 parity, 1 system error, 2 target abort
  function automatic int flag_pos(input int idx);
    case (idx)
      0:       return 15;
      1:       return 14;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/stsreg_sticky_bank.sv
module stsreg_sticky_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o[g] <= 1'b0;
      else        flag_o[g] <= set_i[g] | (flag_o[g] & ~clr_i[g]);
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_o[g]);
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[g] && !set_i[g]) |=> $stable(flag_o[g]));
  end
endmodule

// File: rtl/stsreg_irq_stage.sv
module stsreg_irq_stage #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] src_en_i,
  input  logic            int_dis_i,
  output logic            int_stat_o,
  output logic            intx_n_o
);
  logic pending;
  assign pending = |(src_i & src_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_stat_o <= 1'b0;
      intx_n_o   <= 1'b1;
    end else begin
      int_stat_o <= pending;
      intx_n_o   <= ~(pending & ~int_dis_i);
    end
  end

  assert_masked_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_dis_i |=> intx_n_o);
  assert_active_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !int_dis_i) |=> !intx_n_o);
  assert_stat_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> int_stat_o);
  assert_pin_implies_stat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !intx_n_o |-> int_stat_o);
endmodule

// File: rtl/cfg_status_reg.sv
module cfg_status_reg
  import stsreg_pkg::*;
#(
  parameter int IRQ_SRCS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_be,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  input  logic                evt_addr_par,
  input  logic                evt_data_par,
  input  logic                evt_sys_err,
  input  logic                serr_en,
  input  logic                evt_tgt_abort,
  input  logic [IRQ_SRCS-1:0] irq_src,
  input  logic [IRQ_SRCS-1:0] irq_src_en,
  input  logic                int_dis,
  output logic                intx_n
);
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
  logic             int_stat;

  assign flag_set[0] = evt_addr_par | evt_data_par;
  assign flag_set[1] = evt_sys_err & serr_en;
  assign flag_set[2] = evt_tgt_abort;

  for (genvar g = 0; g < NFLAG; g++) begin : g_clr
    localparam int POS = flag_pos(g);
    assign flag_clr[g] = wr_en & wr_be[POS / LANE_W] & wr_data[POS];
  end

  stsreg_sticky_bank #(.N(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flag_q)
  );

  stsreg_irq_stage #(.NSRC(IRQ_SRCS)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (irq_src),
    .src_en_i   (irq_src_en),
    .int_dis_i  (int_dis),
    .int_stat_o (int_stat),
    .intx_n_o   (intx_n)
  );

  always_comb begin
    rd_data = CONST_WORD;
    for (int i = 0; i < NFLAG; i++) rd_data[flag_pos(i)] = flag_q[i];
    rd_data[BIT_IRQ] = int_stat;
  end

  assert_parity_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_addr_par || evt_data_par) |=> rd_data[15]);
  assert_serr_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(evt_sys_err && serr_en) && !rd_data[14]) |=> !rd_data[14]);
  assert_tabort_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tgt_abort |=> rd_data[11]);
  assert_lane_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_be[1] && !evt_addr_par && !evt_data_par && rd_data[15]) |=> rd_data[15]);
endmodule

// File: tb/cfg_status_reg_bench.sv
`timescale 1ns/1ps
module cfg_status_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic        evt_addr_par = 0, evt_data_par = 0, evt_sys_err = 0, serr_en = 0, evt_tgt_abort = 0;
  logic [3:0]  irq_src = 4'h0, irq_src_en = 4'h0;
  logic        int_dis = 1'b0;
  logic        intx_n;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cfg_status_reg #(.IRQ_SRCS(4)) u_cfg_status_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .evt_addr_par(evt_addr_par), .evt_data_par(evt_data_par),
    .evt_sys_err(evt_sys_err), .serr_en(serr_en), .evt_tgt_abort(evt_tgt_abort),
    .irq_src(irq_src), .irq_src_en(irq_src_en), .int_dis(int_dis), .intx_n(intx_n)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_be = 2'b00; wr_data = 16'h0;
    evt_addr_par = 0; evt_data_par = 0; evt_sys_err = 0; serr_en = 0; evt_tgt_abort = 0;
  endtask

  // inputs are driven 1 ns after an edge; results sampled 1 ns after the next edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic m15, m14, m11;
    m15 = 0; m14 = 0; m11 = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset word", rd_data, 16'h0210);
    chk("R1 reset intx_n", {15'h0, intx_n}, 16'h1);
    rst_n = 1'b1;
    tick();
    chk("R1 word after reset", rd_data, 16'h0210);
    chk("R1 intx_n after reset", {15'h0, intx_n}, 16'h1);

    // flag sweep: events x clear bits x lane enables
    for (int e = 0; e < 32; e++) begin
      for (int w = 0; w < 8; w++) begin
        for (int b = 0; b < 4; b++) begin
          logic s15, s14, s11, clr_ok;
          evt_addr_par = e[0]; evt_data_par = e[1]; evt_sys_err = e[2];
          serr_en = e[3]; evt_tgt_abort = e[4];
          wr_en = 1'b1; wr_be = b[1:0];
          wr_data = 16'h37FF | {w[0], w[1], 2'b00, w[2], 11'h0};
          s15 = e[0] | e[1]; s14 = e[2] & e[3]; s11 = e[4];
          clr_ok = b[1];
          m15 = s15 | (m15 & ~(clr_ok & w[0]));
          m14 = s14 | (m14 & ~(clr_ok & w[1]));
          m11 = s11 | (m11 & ~(clr_ok & w[2]));
          tick();
          chk("R2 parity flag bit15", {15'h0, rd_data[15]}, {15'h0, m15});
          chk("R3 sys error flag bit14", {15'h0, rd_data[14]}, {15'h0, m14});
          chk("R4 target abort flag bit11", {15'h0, rd_data[11]}, {15'h0, m11});
          chk("R7 constant bits", rd_data & 16'h37FF, 16'h0210);
        end
      end
    end
    idle();

    // directed write-one-to-clear cases
    wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF;
    tick();
    idle();
    chk("R5 clear all flags", rd_data, 16'h0210);
    evt_data_par = 1;
    tick();
    idle();
    chk("R2 data parity alone", rd_data, 16'h8210);
    wr_en = 1; wr_be = 2'b11; wr_data = 16'h4800;
    tick();
    idle();
    chk("R5 written zero keeps bit15", rd_data, 16'h8210);
    wr_en = 1; wr_be = 2'b01; wr_data = 16'h8000;
    tick();
    idle();
    chk("R5 disabled lane keeps bit15", rd_data, 16'h8210);
    wr_en = 1; wr_be = 2'b10; wr_data = 16'h8000;
    tick();
    idle();
    chk("R5 enabled lane clears bit15", rd_data, 16'h0210);
    evt_sys_err = 1; serr_en = 0;
    tick();
    idle();
    chk("R3 strobe without enable", rd_data, 16'h0210);
    evt_tgt_abort = 1; wr_en = 1; wr_be = 2'b11; wr_data = 16'h0800;
    tick();
    idle();
    chk("R6 set wins over clear", rd_data, 16'h0A10);
    wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF;
    tick();
    idle();
    chk("R5 final clear", rd_data, 16'h0210);

    // interrupt sweep, with writes of all ones each cycle
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 16; s++) begin
        for (int n = 0; n < 16; n++) begin
          logic pend;
          irq_src = s[3:0]; irq_src_en = n[3:0]; int_dis = d[0];
          wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF;
          pend = |(s[3:0] & n[3:0]);
          tick();
          chk("R8 interrupt status bit3", {15'h0, rd_data[3]}, {15'h0, pend});
          chk("R9 intx_n level", {15'h0, intx_n}, {15'h0, ~(pend & ~d[0])});
        end
      end
    end

    // toggling the disable alone must move the pin but not bit 3
    irq_src = 4'h1; irq_src_en = 4'h1; int_dis = 0; idle();
    tick();
    chk("R9 pin active", {15'h0, intx_n}, 16'h0);
    int_dis = 1;
    tick();
    chk("R9 pin masked", {15'h0, intx_n}, 16'h1);
    chk("R8 bit3 unchanged by mask", rd_data, 16'h0218);
    irq_src = 4'h0;
    tick();
    chk("R8 bit3 drops with source", rd_data, 16'h0210);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule